// File: doc/BRIEF.md
# Two-Stage Baud Tick Generator

This block derives a 16x bit-rate enable from the system clock in two stages. A prescaler divides the clock by 1, 3, 4 or 5. A second stage then divides the prescaler's enable by a ratio taken from a fixed table. Some entries in that table are thirds (16/3, 32/3, 58/3). The block meets those exactly on average by repeating a short three-period pattern. One code bypasses the second stage altogether. The output is a one-cycle pulse, `tick16`, which is high once per sixteenth of a bit period and serves as a clock enable for a serial transmitter and receiver.

Software sets everything with one control byte written under a strobe. Bits 1:0 hold the prescale code, bits 6:2 the divisor code, and bit 7 the clock-out select. The select bit appears on `clkout_sel` and drives a clock-out mux outside this block: 0 routes the raw input clock, 1 routes the generated 16x rate. Reset clears the counters but leaves the control byte as it was. Every write restarts both stages from zero, so the first pulse comes a full period after the write.

Top module: `baud_tick_gen`

## Requirements
- R1: The prescale code in bits 1:0 selects a first-stage ratio of 1 (code 0), 3 (code 1), 4 (code 2) or 5 (code 3).
- R2: Divisor codes 0 to 16 (bits 6:2) select whole or third ratios. The whole ratios are 2, 4, 8, 16, 22, 32, 64, 128, 192, 256, 288, 352, 512 and 768, at codes 0, 1, 3, 5, 7, 8, 9, 10, 11, 12, 13, 14, 15 and 16 respectively. A whole ratio L gives a pulse every P*L cycles, where P is the prescale ratio.
- R3: Code 2 (16/3) cycles its periods as 5, 5, 6. Code 4 (32/3) cycles them as 11, 11, 10. Code 6 (58/3) cycles them as 19, 19, 20. Each pattern starts at its first entry after a write or a reset and repeats indefinitely. Each period is measured in prescaler enables.
- R4: Divisor code 31 bypasses the second stage. With prescale code 0 this gives a pulse on every cycle.
- R5: Divisor codes 17 to 30 behave as ratio 2.
- R6: `tick16` is high for a single cycle at a time. The first pulse after a write is high in the cycle that ends P*L0 rising edges after the write edge, where L0 is the first period. Each later pulse follows the previous one by P times the current period.
- R7: A write loads the new byte and clears both counters and the pattern position on the same edge. Any count already in progress is abandoned.
- R8: `clkout_sel` equals bit 7 of the most recent write and is not changed by reset.
- R9: While reset is asserted, `tick16` stays low. After reset is released, counting restarts from zero with the retained control byte, and no rewrite is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset of the counters |
| cfg_wr | input | 1 | Write strobe for the control byte |
| cfg_byte | input | 8 | Control byte: prescale [1:0], divisor [6:2], clock-out select [7] |
| tick16 | output | 1 | One-cycle pulse at 16 times the bit rate |
| clkout_sel | output | 1 | Clock-out source select: 0 input clock, 1 generated rate |

## Verification
The bench sweeps every prescale code against every listed divisor code and the bypass code. For each combination it matches the exact cycle index of every pulse after the write, so a wrong prescale ratio and a wrong table entry produce different offsets. Each third ratio runs for four pulses, which shows that the pattern wraps back to its first period; an off-by-one in the dither order moves the first or fourth pulse. Several unlisted codes separate the divide-by-2 default from the bypass. A rewrite partway through a count, and a reset partway through a run, show whether the counters really restart and whether the byte survives reset.

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int CW = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_byte,
  output logic       tick16,
  output logic       clkout_sel
);

  logic [7:0]    cfg;
  logic [2:0]    pcnt;
  logic [CW-1:0] dcnt;
  logic [1:0]    ph;
  logic [2:0]    pre_ratio;
  logic [CW-1:0] cur_len;
  logic          pre_en;
  logic          seen;

  always_ff @(posedge clk)
    if (cfg_wr) cfg <= cfg_byte;

  always_comb
    case (cfg[1:0])
      2'd0:    pre_ratio = 3'd1;
      2'd1:    pre_ratio = 3'd3;
      2'd2:    pre_ratio = 3'd4;
      default: pre_ratio = 3'd5;
    endcase

  always_comb
    case (cfg[6:2])
      5'd0:    cur_len = CW'(2);
      5'd1:    cur_len = CW'(4);
      5'd2:    cur_len = (ph == 2'd2) ? CW'(6)  : CW'(5);
      5'd3:    cur_len = CW'(8);
      5'd4:    cur_len = (ph == 2'd2) ? CW'(10) : CW'(11);
      5'd5:    cur_len = CW'(16);
      5'd6:    cur_len = (ph == 2'd2) ? CW'(20) : CW'(19);
      5'd7:    cur_len = CW'(22);
      5'd8:    cur_len = CW'(32);
      5'd9:    cur_len = CW'(64);
      5'd10:   cur_len = CW'(128);
      5'd11:   cur_len = CW'(192);
      5'd12:   cur_len = CW'(256);
      5'd13:   cur_len = CW'(288);
      5'd14:   cur_len = CW'(352);
      5'd15:   cur_len = CW'(512);
      5'd16:   cur_len = CW'(768);
      5'd31:   cur_len = CW'(1);
      default: cur_len = CW'(2);
    endcase

  assign pre_en     = (pcnt == pre_ratio - 3'd1);
  assign tick16     = rst_n && pre_en && (dcnt == cur_len - CW'(1));
  assign clkout_sel = cfg[7];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pcnt <= '0;
      dcnt <= '0;
      ph   <= '0;
    end else if (cfg_wr) begin
      pcnt <= '0;
      dcnt <= '0;
      ph   <= '0;
    end else if (pre_en) begin
      pcnt <= '0;
      if (dcnt == cur_len - CW'(1)) begin
        dcnt <= '0;
        ph   <= (ph == 2'd2) ? 2'd0 : ph + 2'd1;
      end else begin
        dcnt <= dcnt + CW'(1);
      end
    end else begin
      pcnt <= pcnt + 3'd1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      seen <= 1'b0;
    else if (cfg_wr) seen <= 1'b1;

  p_pre_bound_r1: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    pcnt < pre_ratio);

  p_div_bound_r3: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    (dcnt < cur_len) && (ph != 2'd3));

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    (tick16 && !cfg_wr && !(cfg[1:0] == 2'd0 && cfg[6:2] == 5'd31)) |=> !tick16);

  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !(cfg_byte[1:0] == 2'd0 && cfg_byte[6:2] == 5'd31)) |=> !tick16);

  p_sel_hold_r8: assert property (@(posedge clk) disable iff (!seen)
    !cfg_wr |=> $stable(clkout_sel));

endmodule

// File: tb/sim_baud_tick_gen.sv
`timescale 1ns/1ps
module sim_baud_tick_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_byte = 8'h00;
  logic       tick16;
  logic       clkout_sel;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  baud_tick_gen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_byte(cfg_byte),
    .tick16(tick16), .clkout_sel(clkout_sel)
  );

  function automatic int pre_of(input logic [1:0] c);
    case (c)
      2'd0: return 1;
      2'd1: return 3;
      2'd2: return 4;
      default: return 5;
    endcase
  endfunction

  function automatic int len_of(input logic [4:0] c, input int ph);
    case (c)
      5'd0: return 2;   5'd1: return 4;
      5'd2: return (ph == 2) ? 6 : 5;
      5'd3: return 8;
      5'd4: return (ph == 2) ? 10 : 11;
      5'd5: return 16;
      5'd6: return (ph == 2) ? 20 : 19;
      5'd7: return 22;  5'd8: return 32;   5'd9: return 64;
      5'd10: return 128; 5'd11: return 192; 5'd12: return 256;
      5'd13: return 288; 5'd14: return 352; 5'd15: return 512;
      5'd16: return 768; 5'd31: return 1;
      default: return 2;
    endcase
  endfunction

  task automatic check(input logic act, input logic expv, input string req, input int idx);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s idx %0d: actual %0b expected %0b", req, idx, act, expv);
    end
  endtask

  task automatic write_cfg(input logic [7:0] b);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_byte = b;
    @(negedge clk);
    cfg_wr = 1'b0;
    #0.5;
  endtask

  // follow pulses from index 0 (the current sample point) for nt pulses
  task automatic follow(input logic [7:0] b, input int nt, input string req);
    int p = pre_of(b[1:0]);
    int ph = 0;
    int j = 0;
    int nxt = p * len_of(b[6:2], 0) - 1;
    for (int k = 0; j < nt; k++) begin
      if (k > 0) begin @(negedge clk); #0.5; end
      if (k == nxt) begin
        check(tick16, 1'b1, req, k);
        j++;
        ph = (ph + 1) % 3;
        nxt = nxt + p * len_of(b[6:2], ph);
      end else begin
        check(tick16, 1'b0, req, k);
      end
    end
  endtask

  task automatic run(input logic [7:0] b, input int nt, input string req);
    write_cfg(b);
    check(clkout_sel, b[7], "R8 clkout", 0);
    follow(b, nt, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    check(tick16, 1'b0, "R9 reset state", 0);

    // R1 R2 R3 R4: full prescale x divisor sweep
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c <= 16; c++) begin
        logic [7:0] b = {1'(p[0] ^ c[0]), 5'(c), 2'(p)};
        if (c == 2 || c == 4 || c == 6) run(b, 4, "R3 third ratio");
        else run(b, 2, "R2 R1 whole ratio");
      end
      run({1'b1, 5'd31, 2'(p)}, 3, "R4 bypass");
    end

    // R5: unlisted divisor codes act as ratio 2
    run({1'b0, 5'd17, 2'd1}, 3, "R5 unlisted");
    run({1'b1, 5'd23, 2'd0}, 3, "R5 unlisted");
    run({1'b0, 5'd30, 2'd3}, 3, "R5 unlisted");

    // R6 R7: the 86h example, then a rewrite partway through a count
    run(8'h86, 3, "R6 pulse spacing");
    write_cfg(8'h14);
    for (int k = 0; k < 8; k++) begin
      if (k > 0) begin @(negedge clk); #0.5; end
      check(tick16, 1'b0, "R7 before rewrite", k);
    end
    run(8'h14, 2, "R7 restart");

    // R8 R9: reset mid-run keeps the byte and restarts counting
    write_cfg(8'h85);
    repeat (7) @(negedge clk);
    rst_n = 1'b0;
    for (int k = 0; k < 6; k++) begin
      #0.5;
      check(tick16, 1'b0, "R9 during reset", k);
      check(clkout_sel, 1'b1, "R8 kept in reset", k);
      @(negedge clk);
    end
    rst_n = 1'b1;
    #0.5;
    follow(8'h85, 3, "R9 after release");
    check(clkout_sel, 1'b1, "R8 after reset", 0);

    // R9: the bypass config must stay quiet while reset is held
    write_cfg(8'h7C);
    check(tick16, 1'b1, "R4 every cycle", 0);
    @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    check(tick16, 1'b0, "R9 bypass in reset", 0);
    check(clkout_sel, 1'b0, "R8 low kept", 0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule